// File: doc/BRIEF.md
# Stream Table Entry Locator

This block turns a stream identifier into the byte address of the 64-byte configuration entry that belongs to that stream. Software picks one of two table layouts. In the flat layout the entries sit in one contiguous array, and the block computes the address in a single cycle. In the split layout the stream identifier is cut in two. The upper part selects an 8-byte descriptor in a first-level array. The block reads that descriptor through a memory read port. The descriptor supplies a span, which bounds the lower part, and a pointer to a second-level array of entries.

A requester raises a one-cycle request strobe together with the stream identifier. The result comes back as a one-cycle done strobe that carries either an entry address or a fault code. Fault code 3 (fetch abort) also carries the address whose read was aborted. The block does not decode the entry itself.

Top module: `strtab_locator`

## Requirements
- R1: After synchronous reset, `done`, `rd_req` and `busy` are low and the layout is flat.
- R2: A stream identifier greater than 2^SID_BITS (256 by default) completes one cycle after the request with fault code 1 (bad identifier), `flt_addr` 0 and no memory read. An identifier equal to 256 is accepted.
- R3: In the flat layout a valid request completes one cycle later with fault code 0, `ent_addr` = `tab_base` + sid*64 (base not masked), and no memory read.
- R4: A cycle with `cfg_wr` high and `cfg_fmt` = 1 selects the split layout from the next cycle and latches `cfg_split`. A write with `cfg_fmt` = 0 returns the block to the flat layout.
- R5: In the split layout a valid request raises `rd_req` for exactly one cycle, one cycle after the request. The read address is `tab_base` with bits 5:0 cleared, plus (sid >> split)*8.
- R6: A returned descriptor whose span field, bits 4:0, is zero completes with fault code 1.
- R7: The second-level index is the low `split` bits of sid. An index greater than 2^span-1 completes with fault code 2 (bad entry) and `flt_addr` 0. An index equal to 2^span-1 is accepted.
- R8: On an accepted descriptor the block completes one cycle after `rd_vld` with fault code 0 and `ent_addr` = {descriptor bits 51:6, 6'b0} + index*64. Descriptor bits 63:52 and 5 are ignored.
- R9: A response with `rd_err` high completes with fault code 3, and `flt_addr` equals the descriptor address that was read.
- R10: While a lookup waits for its descriptor, new requests are ignored. `rd_vld` arriving while idle produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Table configuration write strobe |
| cfg_fmt | input | 1 | Layout select: 1 split, 0 flat |
| cfg_split | input | 5 | Number of low identifier bits that form the second-level index |
| tab_base | input | AW | Table base address |
| req | input | 1 | Lookup request strobe |
| sid | input | SID_W | Stream identifier |
| busy | output | 1 | Waiting for a descriptor |
| done | output | 1 | Lookup complete (one cycle) |
| ent_addr | output | AW | Entry address when the fault code is 0 |
| flt_code | output | 2 | 0 none, 1 bad identifier, 2 bad entry, 3 fetch abort |
| flt_addr | output | AW | Aborted read address for fault code 3, else 0 |
| rd_req | output | 1 | Descriptor read strobe |
| rd_addr | output | AW | Descriptor read address |
| rd_vld | input | 1 | Read response valid |
| rd_data | input | 64 | Descriptor data |
| rd_err | input | 1 | Read response aborted |

## Verification
The hardest case to reach is a request that arrives while a split-layout lookup is still waiting for its descriptor. If the block took that request, it would overwrite the captured identifier or issue a second read. The bench holds back the memory response for several cycles and injects a second request with a different first-level index during that window. It then checks that no second read appears and that the final address belongs to the first identifier. Descriptors that carry stray upper and low bits, spans at their exact limit, and a split equal to the identifier width are covered by the vector table.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_BAD_SID = 2'd1,
    FLT_BAD_ENT = 2'd2,
    FLT_FETCH   = 2'd3
  } flt_e;

  localparam int ENT_SHIFT  = 6;
  localparam int DESC_SHIFT = 3;
  localparam int SPAN_W     = 5;
  localparam int SPLIT_W    = 5;
endpackage

// File: rtl/slt_cfg.sv
module slt_cfg
  import slt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_fmt,
  input  logic [SPLIT_W-1:0] cfg_split,
  output logic               two_lvl,
  output logic [SPLIT_W-1:0] split
);
  always_ff @(posedge clk) begin
    if (rst) begin
      two_lvl <= 1'b0;
      split   <= '0;
    end else if (cfg_wr) begin
      two_lvl <= cfg_fmt;
      if (cfg_fmt) split <= cfg_split;
    end
  end

  // R4: a format-1 write selects the split layout and latches the split field
  assert_fmt_latch_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_fmt) |=> (two_lvl && split == $past(cfg_split)));
  assert_fmt_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_fmt) |=> !two_lvl);
endmodule

// File: rtl/slt_index.sv
module slt_index
  import slt_pkg::*;
#(
  parameter int SID_W = 16
) (
  input  logic [SID_W-1:0]   sid,
  input  logic [SPLIT_W-1:0] split,
  output logic [SID_W-1:0]   l1_idx,
  output logic [SID_W-1:0]   l2_idx
);
  logic [SID_W-1:0] low_mask;

  always_comb begin
    low_mask = ~({SID_W{1'b1}} << split);
    l1_idx   = sid >> split;
    l2_idx   = sid & low_mask;
  end
endmodule

// File: rtl/slt_addr_gen.sv
module slt_addr_gen
  import slt_pkg::*;
#(
  parameter int SID_W = 16,
  parameter int AW    = 52
) (
  input  logic [AW-1:0]    base,
  input  logic [SID_W-1:0] sid,
  input  logic [SID_W-1:0] l1_idx,
  input  logic [SID_W-1:0] l2_idx,
  input  logic [63:0]      desc,
  output logic [AW-1:0]    lin_addr,
  output logic [AW-1:0]    desc_addr,
  output logic [AW-1:0]    ent_addr,
  output logic             span_zero,
  output logic             l2_over
);
  localparam int PAD   = AW - SID_W;
  localparam int CMP_W = ((SID_W > 32) ? SID_W : 32) + 1;
  localparam logic [CMP_W-1:0] ONE = {{(CMP_W-1){1'b0}}, 1'b1};

  logic [AW-1:0]     base_al;
  logic [AW-1:0]     next_ptr;
  logic [SPAN_W-1:0] span;
  logic [CMP_W-1:0]  span_lim;
  logic [CMP_W-1:0]  l2_wide;

  always_comb begin
    base_al   = {base[AW-1:ENT_SHIFT], {ENT_SHIFT{1'b0}}};
    lin_addr  = base + ({{PAD{1'b0}}, sid} << ENT_SHIFT);
    desc_addr = base_al + ({{PAD{1'b0}}, l1_idx} << DESC_SHIFT);
    next_ptr  = {desc[AW-1:ENT_SHIFT], {ENT_SHIFT{1'b0}}};
    ent_addr  = next_ptr + ({{PAD{1'b0}}, l2_idx} << ENT_SHIFT);
    span      = desc[SPAN_W-1:0];
    span_zero = (span == '0);
    span_lim  = (ONE << span) - ONE;
    l2_wide   = {{(CMP_W-SID_W){1'b0}}, l2_idx};
    l2_over   = (l2_wide > span_lim);
  end
endmodule

// File: rtl/slt_ctrl.sv
module slt_ctrl
  import slt_pkg::*;
#(
  parameter int SID_W    = 16,
  parameter int SID_BITS = 8,
  parameter int AW       = 52
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [SID_W-1:0]   sid,
  input  logic               two_lvl,
  input  logic [SPLIT_W-1:0] split,
  input  logic [AW-1:0]      lin_addr,
  input  logic [AW-1:0]      desc_addr,
  input  logic [AW-1:0]      ent_addr_2l,
  input  logic               span_zero,
  input  logic               l2_over,
  input  logic               rd_vld,
  input  logic               rd_err,
  output logic [SID_W-1:0]   cur_sid,
  output logic [SPLIT_W-1:0] cur_split,
  output logic               busy,
  output logic               done,
  output logic [AW-1:0]      ent_addr,
  output logic [1:0]         flt_code,
  output logic [AW-1:0]      flt_addr,
  output logic               rd_req,
  output logic [AW-1:0]      rd_addr
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  localparam logic [SID_W:0] SID_LIM = {{SID_W{1'b0}}, 1'b1} << SID_BITS;

  st_e               state;
  logic [SID_W-1:0]  sid_q;
  logic [SPLIT_W-1:0] split_q;
  logic              sid_bad;

  always_comb begin
    sid_bad   = ({1'b0, sid} > SID_LIM);
    busy      = (state == ST_WAIT);
    cur_sid   = busy ? sid_q : sid;
    cur_split = busy ? split_q : split;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sid_q    <= '0;
      split_q  <= '0;
      done     <= 1'b0;
      ent_addr <= '0;
      flt_code <= FLT_NONE;
      flt_addr <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
    end else begin
      done   <= 1'b0;
      rd_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            if (sid_bad) begin
              done     <= 1'b1;
              flt_code <= FLT_BAD_SID;
              ent_addr <= '0;
              flt_addr <= '0;
            end else if (two_lvl) begin
              rd_req  <= 1'b1;
              rd_addr <= desc_addr;
              sid_q   <= sid;
              split_q <= split;
              state   <= ST_WAIT;
            end else begin
              done     <= 1'b1;
              flt_code <= FLT_NONE;
              ent_addr <= lin_addr;
              flt_addr <= '0;
            end
          end
        end
        ST_WAIT: begin
          if (rd_vld) begin
            done  <= 1'b1;
            state <= ST_IDLE;
            if (rd_err) begin
              flt_code <= FLT_FETCH;
              ent_addr <= '0;
              flt_addr <= rd_addr;
            end else if (span_zero) begin
              flt_code <= FLT_BAD_SID;
              ent_addr <= '0;
              flt_addr <= '0;
            end else if (l2_over) begin
              flt_code <= FLT_BAD_ENT;
              ent_addr <= '0;
              flt_addr <= '0;
            end else begin
              flt_code <= FLT_NONE;
              ent_addr <= ent_addr_2l;
              flt_addr <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: out-of-range identifier completes at once with a bad-identifier fault
  assert_bad_sid_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && req && ({1'b0, sid} > SID_LIM)) |=>
      (done && flt_code == FLT_BAD_SID && !rd_req));
  // R5: descriptor reads are 8-byte aligned
  assert_desc_align_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr[DESC_SHIFT-1:0] == '0));
  // R5 / R10: one read strobe per lookup, followed by waiting
  assert_one_read_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  assert_wait_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);
  // R9: an aborted response completes with a fetch fault
  assert_fetch_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_vld && rd_err) |=> (done && flt_code == FLT_FETCH && !busy));
  // R10: a response while idle produces no completion
  assert_idle_vld_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req && rd_vld) |=> !done);
  // R8: accepted two-level result is entry aligned
  assert_ent_align_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_vld && !rd_err && !span_zero && !l2_over) |=>
      (done && flt_code == FLT_NONE && ent_addr[ENT_SHIFT-1:0] == '0));
endmodule

// File: rtl/strtab_locator.sv
module strtab_locator
  import slt_pkg::*;
#(
  parameter int SID_W    = 16,
  parameter int SID_BITS = 8,
  parameter int AW       = 52
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_fmt,
  input  logic [SPLIT_W-1:0] cfg_split,
  input  logic [AW-1:0]      tab_base,
  input  logic               req,
  input  logic [SID_W-1:0]   sid,
  output logic               busy,
  output logic               done,
  output logic [AW-1:0]      ent_addr,
  output logic [1:0]         flt_code,
  output logic [AW-1:0]      flt_addr,
  output logic               rd_req,
  output logic [AW-1:0]      rd_addr,
  input  logic               rd_vld,
  input  logic [63:0]        rd_data,
  input  logic               rd_err
);
  logic               two_lvl;
  logic [SPLIT_W-1:0] split;
  logic [SID_W-1:0]   cur_sid;
  logic [SPLIT_W-1:0] cur_split;
  logic [SID_W-1:0]   l1_idx;
  logic [SID_W-1:0]   l2_idx;
  logic [AW-1:0]      lin_addr;
  logic [AW-1:0]      desc_addr;
  logic [AW-1:0]      ent_addr_2l;
  logic               span_zero;
  logic               l2_over;

  slt_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt),
    .cfg_split(cfg_split), .two_lvl(two_lvl), .split(split)
  );

  slt_index #(.SID_W(SID_W)) u_idx (
    .sid(cur_sid), .split(cur_split), .l1_idx(l1_idx), .l2_idx(l2_idx)
  );

  slt_addr_gen #(.SID_W(SID_W), .AW(AW)) u_agen (
    .base(tab_base), .sid(cur_sid), .l1_idx(l1_idx), .l2_idx(l2_idx),
    .desc(rd_data), .lin_addr(lin_addr), .desc_addr(desc_addr),
    .ent_addr(ent_addr_2l), .span_zero(span_zero), .l2_over(l2_over)
  );

  slt_ctrl #(.SID_W(SID_W), .SID_BITS(SID_BITS), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .sid(sid), .two_lvl(two_lvl),
    .split(split), .lin_addr(lin_addr), .desc_addr(desc_addr),
    .ent_addr_2l(ent_addr_2l), .span_zero(span_zero), .l2_over(l2_over),
    .rd_vld(rd_vld), .rd_err(rd_err), .cur_sid(cur_sid),
    .cur_split(cur_split), .busy(busy), .done(done), .ent_addr(ent_addr),
    .flt_code(flt_code), .flt_addr(flt_addr), .rd_req(rd_req),
    .rd_addr(rd_addr)
  );

  // R1: nothing completes or reads in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!done && !rd_req && !busy));
endmodule

// File: tb/sim_strtab_locator.sv
module sim_strtab_locator;
  localparam int SID_W = 16;
  localparam int AW    = 52;
  localparam int NV    = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_fmt = 1'b0;
  logic [4:0] cfg_split = '0;
  logic [AW-1:0] tab_base = '0;
  logic req = 1'b0;
  logic [SID_W-1:0] sid = '0;
  logic busy, done, rd_req;
  logic [AW-1:0] ent_addr, flt_addr, rd_addr;
  logic [1:0] flt_code;
  logic rd_vld = 1'b0, rd_err = 1'b0;
  logic [63:0] rd_data = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  strtab_locator u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt),
    .cfg_split(cfg_split), .tab_base(tab_base), .req(req), .sid(sid),
    .busy(busy), .done(done), .ent_addr(ent_addr), .flt_code(flt_code),
    .flt_addr(flt_addr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_vld(rd_vld), .rd_data(rd_data), .rd_err(rd_err)
  );

  // vector fields: layout, split, base, sid, descriptor, abort, read expected,
  // expected read address, expected code, expected entry/fault address
  localparam logic       V_FMT [NV] = '{0,0,0,0,1,1,1,1,1,1,1,1,1};
  localparam logic [4:0] V_SPL [NV] = '{0,0,0,0,4,4,4,4,4,0,4,4,8};
  localparam logic [63:0] V_BASE [NV] = '{
    64'h1000, 64'h2010, 64'h0, 64'h0, 64'h10030, 64'h10000, 64'h10000,
    64'h10000, 64'h10000, 64'h10000, 64'h10000, 64'h10000, 64'h10000};
  localparam logic [15:0] V_SID [NV] = '{
    16'd5, 16'd0, 16'd256, 16'd257, 16'h35, 16'h27, 16'h28, 16'h11,
    16'h42, 16'd9, 16'd300, 16'h13, 16'h35};
  localparam logic [63:0] V_DESC [NV] = '{
    64'h0, 64'h0, 64'h0, 64'h0, 64'h80003, 64'h40003, 64'h40003,
    64'h40000, 64'h0, 64'h123441, 64'h0, 64'hFFF0_0000_0008_0022,
    64'h200006};
  localparam logic V_ERR [NV] = '{0,0,0,0,0,0,0,0,1,0,0,0,0};
  localparam logic V_RD  [NV] = '{0,0,0,0,1,1,1,1,1,1,0,1,1};
  localparam logic [63:0] V_RDA [NV] = '{
    64'h0, 64'h0, 64'h0, 64'h0, 64'h10018, 64'h10010, 64'h10010,
    64'h10008, 64'h10020, 64'h10048, 64'h0, 64'h10008, 64'h10000};
  localparam logic [1:0] V_CODE [NV] = '{0,0,0,1,0,0,2,1,3,0,1,0,0};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h1140, 64'h2010, 64'h4000, 64'h0, 64'h80140, 64'h401C0, 64'h0,
    64'h0, 64'h10020, 64'h123440, 64'h0, 64'h800C0, 64'h200D40};

  function automatic string tag_of(int i);
    case (i)
      0, 1:   return "R3";
      2, 3:   return "R2";
      4, 9:   return "R5";
      5, 6:   return "R7";
      7:      return "R6";
      8:      return "R9";
      10:     return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_cfg(logic fmt, logic [4:0] spl);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_fmt = fmt; cfg_split = spl;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic respond(logic [63:0] d, logic e);
    @(negedge clk);
    @(negedge clk);
    rd_vld = 1'b1; rd_data = d; rd_err = e;
    @(negedge clk);
    rd_vld = 1'b0; rd_err = 1'b0;
  endtask

  task automatic run_vec(int i);
    string t;
    t = tag_of(i);
    do_cfg(V_FMT[i], V_SPL[i]);
    tab_base = V_BASE[i][AW-1:0];
    req = 1'b1; sid = V_SID[i];
    @(negedge clk);
    req = 1'b0;
    if (V_RD[i]) begin
      chk(t, "rd_req", {63'd0, rd_req}, 64'd1);
      chk(t, "rd_addr", {12'd0, rd_addr}, V_RDA[i]);
      chk(t, "done early", {63'd0, done}, 64'd0);
      respond(V_DESC[i], V_ERR[i]);
    end else begin
      chk(t, "no read", {63'd0, rd_req}, 64'd0);
    end
    chk(t, "done", {63'd0, done}, 64'd1);
    chk(t, "code", {62'd0, flt_code}, {62'd0, V_CODE[i]});
    if (V_CODE[i] == 2'd0) chk(t, "ent_addr", {12'd0, ent_addr}, V_EXP[i]);
    else                  chk(t, "flt_addr", {12'd0, flt_addr}, V_EXP[i]);
    @(negedge clk);
    chk(t, "done pulse", {63'd0, done}, 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset, flat layout
    chk("R1", "done", {63'd0, done}, 64'd0);
    chk("R1", "rd_req", {63'd0, rd_req}, 64'd0);
    chk("R1", "busy", {63'd0, busy}, 64'd0);
    tab_base = 52'h3000; req = 1'b1; sid = 16'd2;
    @(negedge clk);
    req = 1'b0;
    chk("R1", "flat after reset", {12'd0, ent_addr}, 64'h3080);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R4: format-0 write returns to flat layout
    do_cfg(1'b1, 5'd4);
    do_cfg(1'b0, 5'd0);
    tab_base = 52'h1000; req = 1'b1; sid = 16'd5;
    @(negedge clk);
    req = 1'b0;
    chk("R4", "no read", {63'd0, rd_req}, 64'd0);
    chk("R4", "flat ent", {12'd0, ent_addr}, 64'h1140);

    // R10: request while waiting is ignored
    do_cfg(1'b1, 5'd4);
    tab_base = 52'h10000; req = 1'b1; sid = 16'h35;
    @(negedge clk);
    sid = 16'h00;
    chk("R10", "first read", {12'd0, rd_addr}, 64'h10018);
    @(negedge clk);
    req = 1'b0;
    chk("R10", "no second read", {63'd0, rd_req}, 64'd0);
    chk("R10", "busy", {63'd0, busy}, 64'd1);
    rd_vld = 1'b1; rd_data = 64'h80003;
    @(negedge clk);
    rd_vld = 1'b0;
    chk("R10", "done", {63'd0, done}, 64'd1);
    chk("R10", "first sid ent", {12'd0, ent_addr}, 64'h80140);
    // R10: response while idle is ignored
    rd_vld = 1'b1;
    @(negedge clk);
    rd_vld = 1'b0;
    chk("R10", "idle vld done", {63'd0, done}, 64'd0);
    chk("R10", "idle vld busy", {63'd0, busy}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule